// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block produces the STOP condition at the end of an I2C master transfer. Software raises a stop-enable request once the byte and its acknowledge are complete. The block then pulls SDA low and times the rest of the STOP with a 7-bit down-counting period generator. It releases SCL, then SDA, and lets one more period run before it reports completion. SCL stretching by a slave holds the sequence until the clock line is actually seen high.

The block also watches both bus lines. It keeps bus-busy (start seen) and bus-free (stop seen) status bits and raises a sticky interrupt on each bus START or STOP and at the end of its own sequence. A transmit-buffer write that arrives while the sequence runs is refused and latched as a write collision. A write at any other time loads the buffer.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset, `sda_low` and `scl_low` are 0, `stop_en` is 0, `stop_seen`, `start_seen`, `wcol` and `irq` are 0, and `buf_q` is 0.
- R2: A `stop_req_set` pulse sampled while idle sets `stop_en`, and both `sda_low` and `scl_low` are 1 from the next cycle on. The sequence waits in this state for as many edges as `sda_in` is sampled high.
- R3: On the edge that first samples `sda_in` low, the period generator loads `reload`. `scl_low` drops to 0 exactly `reload`+1 edges later.
- R4: After SCL is released, the generator reloads on the first edge that samples `scl_in` high, so each cycle of slave stretching delays the rest of the sequence by one cycle. `sda_low` drops to 0 exactly `reload`+1 edges after that reload.
- R5: The edge that releases SDA reloads the generator. `stop_en` returns to 0 and `irq` is set exactly `reload`+1 edges later. With no stall, `scl_low` falls `reload`+2 edges after the request edge, `sda_low` falls 2·`reload`+4 edges after it, and `stop_en` falls 3·`reload`+5 edges after it.
- R6: A rise of `sda_in` while `scl_in` is high on both edges is a STOP. On that edge `stop_seen` is set, `start_seen` is cleared and `irq` is set.
- R7: A fall of `sda_in` while `scl_in` is high on both edges is a START. On that edge `start_seen` is set, `stop_seen` is cleared and `irq` is set.
- R8: A `buf_wr` sampled while `stop_en` is 1 sets `wcol` and leaves `buf_q` unchanged.
- R9: A `buf_wr` sampled while `stop_en` is 0 loads `buf_wdata` into `buf_q` and leaves `wcol` unchanged.
- R10: `irq` and `wcol` stay at 1 until `clr_irq` or `clr_wcol` is sampled high. A new set event on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload | input | 7 | Period generator reload value |
| stop_req_set | input | 1 | Software request that sets the stop-enable bit |
| stop_en | output | 1 | Stop-enable bit; hardware clears it on completion |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| sda_low | output | 1 | Open-drain pull-down enable for SDA |
| scl_low | output | 1 | Open-drain pull-down enable for SCL |
| buf_wr | input | 1 | Transmit-buffer write strobe |
| buf_wdata | input | 8 | Transmit-buffer write data |
| buf_q | output | 8 | Transmit-buffer contents |
| clr_irq | input | 1 | Clears the interrupt flag |
| clr_wcol | input | 1 | Clears the write-collision flag |
| stop_seen | output | 1 | STOP detected, bus free |
| start_seen | output | 1 | START detected, bus busy |
| wcol | output | 1 | Write-collision flag |
| irq | output | 1 | Interrupt flag |

## Verification
Each phase of the sequence is a fixed number of edges derived from `reload`. A wrong generator value or a wrong state change moves the SCL release, the SDA release or the fall of `stop_en` by at least one cycle. The bench measures each of these edges against its closed-form count for several reload values, with and without SDA sampling delay and SCL stretching. A flag-logic fault shows up on the first edge after the bus event that should set or clear it. A collision fault shows in `wcol` or `buf_q` one cycle after the write.

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq #(
  parameter int RW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reload,
  input  logic          stop_req_set,
  output logic          stop_en,
  input  logic          sda_in,
  input  logic          scl_in,
  output logic          sda_low,
  output logic          scl_low,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  output logic [DW-1:0] buf_q,
  input  logic          clr_irq,
  input  logic          clr_wcol,
  output logic          stop_seen,
  output logic          start_seen,
  output logic          wcol,
  output logic          irq
);

  typedef enum logic [2:0] {IDLE, PULL, HOLD, RISE, SETUP, TAIL} st_t;

  st_t          st;
  logic [RW-1:0] brg;
  logic          sda_q, scl_q;

  wire tmo       = (brg == '0);
  wire done      = (st == TAIL) && tmo;
  wire bus_hi    = scl_in && scl_q;
  wire stop_det  = bus_hi && sda_in && !sda_q;
  wire start_det = bus_hi && !sda_in && sda_q;

  assign stop_en = (st != IDLE);
  assign sda_low = (st == PULL) || (st == HOLD) || (st == RISE) || (st == SETUP);
  assign scl_low = (st == PULL) || (st == HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IDLE;
      brg <= '0;
    end else begin
      case (st)
        IDLE:  if (stop_req_set) st <= PULL;
        PULL:  if (!sda_in) begin brg <= reload; st <= HOLD; end
        HOLD:  if (tmo) st <= RISE; else brg <= brg - 1'b1;
        RISE:  if (scl_in) begin brg <= reload; st <= SETUP; end
        SETUP: if (tmo) begin brg <= reload; st <= TAIL; end
               else brg <= brg - 1'b1;
        TAIL:  if (tmo) st <= IDLE; else brg <= brg - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q      <= 1'b1;
      scl_q      <= 1'b1;
      stop_seen  <= 1'b0;
      start_seen <= 1'b0;
      irq        <= 1'b0;
      wcol       <= 1'b0;
      buf_q      <= '0;
    end else begin
      sda_q <= sda_in;
      scl_q <= scl_in;
      if (stop_det) begin
        stop_seen  <= 1'b1;
        start_seen <= 1'b0;
      end else if (start_det) begin
        start_seen <= 1'b1;
        stop_seen  <= 1'b0;
      end
      if (stop_det || start_det || done) irq <= 1'b1;
      else if (clr_irq)                  irq <= 1'b0;
      if (buf_wr && stop_en) wcol <= 1'b1;
      else if (clr_wcol)     wcol <= 1'b0;
      if (buf_wr && !stop_en) buf_q <= buf_wdata;
    end
  end

  // R2
  req_pulls_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req_set && !stop_en |=> sda_low && scl_low && stop_en);

  // R4
  scl_before_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_low) |-> !scl_low && scl_in);

  // R5
  done_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_en) |-> irq);

  // R6
  stop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> stop_seen && !start_seen && irq);

  // R7
  start_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> start_seen && !stop_seen && irq);

  // R8
  wcol_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr && stop_en |=> wcol && $stable(buf_q));

  // R9
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr && !stop_en |=> buf_q == $past(buf_wdata));

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_irq |=> irq);

endmodule

// File: tb/i2c_stop_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_stop_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] reload = '0;
  logic stop_req_set = 0, buf_wr = 0, clr_irq = 0, clr_wcol = 0;
  logic [7:0] buf_wdata = '0;
  logic ext_sda_low = 0, ext_scl_low = 0, sda_stuck = 0;
  logic stop_en, sda_low, scl_low, stop_seen, start_seen, wcol, irq;
  logic [7:0] buf_q;
  wire sda_in = sda_stuck | (~sda_low & ~ext_sda_low);
  wire scl_in = ~scl_low & ~ext_scl_low;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  i2c_stop_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reload(reload), .stop_req_set(stop_req_set),
    .stop_en(stop_en), .sda_in(sda_in), .scl_in(scl_in), .sda_low(sda_low),
    .scl_low(scl_low), .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_q(buf_q),
    .clr_irq(clr_irq), .clr_wcol(clr_wcol), .stop_seen(stop_seen),
    .start_seen(start_seen), .wcol(wcol), .irq(irq));

  // reload, stretch, sda delay, scl release edge, sda release edge, done edge
  localparam int VEC [0:4][0:5] = '{
    '{3,   0, 0, 5,   10,  14},
    '{0,   0, 0, 2,   4,   5},
    '{10,  3, 0, 12,  27,  38},
    '{5,   0, 2, 9,   16,  22},
    '{127, 1, 0, 129, 259, 387}};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic run_seq(int r, int n, int m, output int t_scl, output int t_sda, output int t_done);
    int cnt;
    t_scl = 0; t_sda = 0; t_done = 0; cnt = 0;
    reload = r[6:0]; stop_req_set = 1; sda_stuck = (m > 0);
    @(posedge clk); @(negedge clk);
    stop_req_set = 0; sda_stuck = (m >= 1);
    for (int c = 1; c < 500 && t_done == 0; c++) begin
      @(posedge clk); @(negedge clk);
      sda_stuck = (c < m);
      if (cnt > 0) begin cnt--; ext_scl_low = (cnt > 0); end
      if (t_scl == 0 && !scl_low) begin
        t_scl = c; cnt = n; ext_scl_low = (n > 0);
      end
      if (t_sda == 0 && t_scl != 0 && !sda_low) t_sda = c;
      if (!stop_en) t_done = c;
    end
    ext_scl_low = 0; sda_stuck = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int ts, td, tq;
    @(negedge clk); @(negedge clk);
    // R1
    check("R1 sda_low", sda_low, 0); check("R1 scl_low", scl_low, 0);
    check("R1 stop_en", stop_en, 0);
    check("R1 flags", {stop_seen, start_seen, wcol, irq}, 0);
    check("R1 buf_q", buf_q, 0);
    rst_n = 1; tick(2);

    for (int v = 0; v < 5; v++) begin
      run_seq(VEC[v][0], VEC[v][1], VEC[v][2], ts, td, tq);
      check("R3 scl release edge", ts, VEC[v][3]);
      check("R4 sda release edge", td, VEC[v][4]);
      check("R5 stop_en clear edge", tq, VEC[v][5]);
      check("R6 stop_seen", stop_seen, 1);
      check("R6 start_seen", start_seen, 0);
      check("R5 irq", irq, 1);
      clr_irq = 1; tick(1); clr_irq = 0;
      check("R10 irq cleared", irq, 0);
    end

    // R2: request drives both lines next cycle
    reload = 7'd4; stop_req_set = 1; tick(1); stop_req_set = 0;
    check("R2 stop_en", stop_en, 1);
    check("R2 lines low", {sda_low, scl_low}, 2'b11);
    while (stop_en) tick(1);
    clr_irq = 1; tick(1); clr_irq = 0;

    // R9: idle write loads buffer
    buf_wdata = 8'h3C; buf_wr = 1; tick(1); buf_wr = 0;
    check("R9 buf_q", buf_q, 8'h3C);
    check("R9 wcol", wcol, 0);

    // R8: write during sequence
    reload = 7'd20; stop_req_set = 1; tick(1); stop_req_set = 0;
    tick(3);
    buf_wdata = 8'hA5; buf_wr = 1; tick(1); buf_wr = 0;
    check("R8 wcol", wcol, 1);
    check("R8 buf_q", buf_q, 8'h3C);
    while (stop_en) tick(1);
    check("R10 wcol sticky", wcol, 1);
    check("R8 buf_q after", buf_q, 8'h3C);
    clr_wcol = 1; tick(1); clr_wcol = 0;
    check("R10 wcol cleared", wcol, 0);
    clr_irq = 1; tick(1); clr_irq = 0;

    // R7: external START
    ext_sda_low = 1; tick(1);
    check("R7 start_seen", start_seen, 1);
    check("R7 stop_seen", stop_seen, 0);
    check("R7 irq", irq, 1);
    tick(3);
    check("R10 irq sticky", irq, 1);
    clr_irq = 1; tick(1); clr_irq = 0;
    // R6: external STOP
    ext_sda_low = 0; tick(1);
    check("R6 ext stop_seen", stop_seen, 1);
    check("R6 ext start_seen", start_seen, 0);
    check("R6 ext irq", irq, 1);

    finish_run();
  end
endmodule